// File: doc/BRIEF.md
# MMU Control and Fault Status Registers

This block holds the processor-visible state that a memory management unit needs around its translation path: a control word (translation enable, a mode that suppresses fault traps, and a store-ordering mode), the physical base of the context table, the current context number, and a pair of fault registers. The processor reads and writes these through a simple select/write port whose address carries the register offset divided by 256. The translation logic itself lives elsewhere. It consumes the enable, table base and context outputs, and it reports faults back through a one-cycle fault strobe.

Each fault report carries a fault type, an access type, the table level at which the walk stopped, eight bus-error bits, a virtual address and a flag that says whether that address is meaningful. The block packs the report into the fault status word and loads the fault address only when the address is meaningful. If a second report arrives before software has read the status word, the block sets an overwrite flag. A trap request pulses for each report unless the trap-suppress mode is on. In that mode faults are still recorded.

Top module: `mmu_fault_regs`

## Requirements
- R1: `cpu_addr` selects the register: 0 control, 1 context-table base, 2 context number, 3 fault status, 4 fault address. Codes 5 to 7 read as zero. Read data is combinational in the cycle `cpu_sel` is high with `cpu_we` low.
- R2: The control word has translation enable in bit 0, trap suppress in bit 1 and store-ordering mode in bit 7, all writable. Bits 31:28 always read `IMPL_ID` and bits 27:24 always read `VERS_ID`, whatever is written. All other bits read zero. `mmu_en` and `store_order` show bits 0 and 7.
- R3: The context-table base keeps written bits 31:2 and reads bits 1:0 as zero. The context number keeps the low `CTX_W` bits written, and its upper bits read zero. Both are driven on `ctx_table_ptr` and `ctx_id`.
- R4: A fault strobe loads the status word in the next cycle with this layout: bus-error bits 17:10, level 9:8, access type 7:5, fault type 4:2, address-valid 1, overwrite 0, and bits 31:18 zero. Fault type codes are 0 none, 1 invalid address, 2 protection, 3 privilege, 4 translation, 5 bus access, 6 internal and 7 reserved. Access type codes are 0/1 user/supervisor data load, 2/3 user/supervisor fetch, 4/5 user/supervisor data store and 6/7 user/supervisor instruction store.
- R5: The fault address register loads `flt_addr` only when `flt_addr_ok` is 1. Otherwise it keeps its value and the address-valid bit becomes 0.
- R6: A fault that arrives while an earlier fault is still unread sets the overwrite bit.
- R7: A processor read of the status word returns its current value, then clears the overwrite and address-valid bits and marks the status as read. A fault in the same cycle as that read is captured with overwrite 0.
- R8: `trap_req` is high for exactly the one cycle after a fault strobe when trap suppress is 0, and stays low when trap suppress is 1.
- R9: Processor writes to the fault status and fault address registers have no effect.
- R10: After reset every writable field is zero, the fault registers are zero and `trap_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | Register access strobe |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | 3 | Register offset divided by 256 |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data |
| flt_valid | input | 1 | Fault report strobe |
| flt_type | input | 3 | Fault type code |
| flt_access | input | 3 | Access type code |
| flt_level | input | 2 | Table level of the fault |
| flt_bus | input | 8 | Bus-error bits |
| flt_addr | input | 32 | Faulting virtual address |
| flt_addr_ok | input | 1 | Fault address is meaningful |
| trap_req | output | 1 | Trap request pulse |
| mmu_en | output | 1 | Translation enable |
| store_order | output | 1 | Store-ordering mode |
| ctx_table_ptr | output | 32 | Context-table base |
| ctx_id | output | 8 | Current context number |

## Verification
The hardest case to reach is a status read and a new fault strobe landing in the same clock edge. In that cycle the read must return the old report while the new report is loaded with its overwrite bit clear. The bench sets this up by leaving one fault unread and then, in a single cycle, raising `cpu_sel` for the status register together with `flt_valid`. It checks the combinational read data during that cycle and the captured word on the next read. The overwrite path is reached by sending a report without an address between two reports with addresses and reading only afterwards. This also shows that the fault address register held its value across the report without an address.

// File: rtl/mmu_fr_pkg.sv
package mmu_fr_pkg;

    localparam int DATA_W = 32;
    localparam int NREG   = 5;

    typedef enum logic [2:0] {
        RS_CTL = 3'd0,
        RS_CTP = 3'd1,
        RS_CTX = 3'd2,
        RS_FSR = 3'd3,
        RS_FAR = 3'd4
    } rsel_e;

    // packed from msb: occupies status bits 17:0
    typedef struct packed {
        logic [7:0] bus;
        logic [1:0] lvl;
        logic [2:0] acc;
        logic [2:0] ftype;
        logic       fav;
        logic       ow;
    } fsr_t;

    typedef struct packed {
        logic pso;
        logic nf;
        logic en;
    } ctl_t;

endpackage

// File: rtl/mmu_fr_decode.sv
module mmu_fr_decode #(
    parameter int ADDR_W = 3,
    parameter int NHIT   = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NHIT-1:0]   hit
);
    for (genvar g = 0; g < NHIT; g++) begin : g_hit
        assign hit[g] = (addr == ADDR_W'(g));
    end
endmodule

// File: rtl/mmu_fr_ctl.sv
module mmu_fr_ctl
    import mmu_fr_pkg::*;
#(
    parameter int CTX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic              wr_ctp,
    input  logic              wr_ctx,
    input  logic [DATA_W-1:0] wdata,
    output ctl_t              ctl,
    output logic [DATA_W-1:0] ctp,
    output logic [CTX_W-1:0]  ctx
);
    localparam int CTP_W = DATA_W - 2;

    typedef struct packed {
        ctl_t             ctl;
        logic [CTP_W-1:0] ctp_hi;
        logic [CTX_W-1:0] ctx;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_ctl) begin
            st_d.ctl.en  = wdata[0];
            st_d.ctl.nf  = wdata[1];
            st_d.ctl.pso = wdata[7];
        end
        if (wr_ctp) st_d.ctp_hi = wdata[DATA_W-1:2];
        if (wr_ctx) st_d.ctx    = wdata[CTX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl = st_q.ctl;
    assign ctp = {st_q.ctp_hi, 2'b00};
    assign ctx = st_q.ctx;
endmodule

// File: rtl/mmu_fr_fault.sv
module mmu_fr_fault
    import mmu_fr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flt_valid,
    input  logic [2:0]        flt_type,
    input  logic [2:0]        flt_access,
    input  logic [1:0]        flt_level,
    input  logic [7:0]        flt_bus,
    input  logic [DATA_W-1:0] flt_addr,
    input  logic              flt_addr_ok,
    input  logic              rd_clr,
    input  logic              nofault,
    output fsr_t              fsr,
    output logic [DATA_W-1:0] far,
    output logic              trap
);
    typedef struct packed {
        fsr_t              fsr;
        logic              unread;
        logic [DATA_W-1:0] far;
        logic              trap;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.trap = 1'b0;
        if (rd_clr) begin
            st_d.fsr.ow  = 1'b0;
            st_d.fsr.fav = 1'b0;
            st_d.unread  = 1'b0;
        end
        if (flt_valid) begin
            st_d.fsr.bus   = flt_bus;
            st_d.fsr.lvl   = flt_level;
            st_d.fsr.acc   = flt_access;
            st_d.fsr.ftype = flt_type;
            st_d.fsr.fav   = flt_addr_ok;
            st_d.fsr.ow    = st_q.unread & ~rd_clr;
            st_d.unread    = 1'b1;
            if (flt_addr_ok) st_d.far = flt_addr;
            st_d.trap      = ~nofault;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fsr  = st_q.fsr;
    assign far  = st_q.far;
    assign trap = st_q.trap;
endmodule

// File: rtl/mmu_fault_regs.sv
module mmu_fault_regs
    import mmu_fr_pkg::*;
#(
    parameter logic [3:0] IMPL_ID = 4'hA,
    parameter logic [3:0] VERS_ID = 4'h3,
    parameter int         CTX_W   = 8,
    parameter int         ADDR_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              flt_valid,
    input  logic [2:0]        flt_type,
    input  logic [2:0]        flt_access,
    input  logic [1:0]        flt_level,
    input  logic [7:0]        flt_bus,
    input  logic [DATA_W-1:0] flt_addr,
    input  logic              flt_addr_ok,
    output logic              trap_req,
    output logic              mmu_en,
    output logic              store_order,
    output logic [DATA_W-1:0] ctx_table_ptr,
    output logic [CTX_W-1:0]  ctx_id
);
    localparam int FSR_W = $bits(fsr_t);

    logic [NREG-1:0]   hit;
    logic              wr, rd, rd_fsr, nofault;
    ctl_t              ctl;
    fsr_t              fsr;
    logic [DATA_W-1:0] fsr_word, far_word, ctl_word;

    mmu_fr_decode #(.ADDR_W(ADDR_W), .NHIT(NREG)) u_dec (
        .addr(cpu_addr), .hit(hit)
    );

    assign wr     = cpu_sel & cpu_we;
    assign rd     = cpu_sel & ~cpu_we;
    assign rd_fsr = rd & hit[RS_FSR];

    mmu_fr_ctl #(.CTX_W(CTX_W)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .wr_ctl(wr & hit[RS_CTL]), .wr_ctp(wr & hit[RS_CTP]),
        .wr_ctx(wr & hit[RS_CTX]), .wdata(cpu_wdata),
        .ctl(ctl), .ctp(ctx_table_ptr), .ctx(ctx_id)
    );

    assign nofault = ctl.nf;

    mmu_fr_fault u_flt (
        .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid),
        .flt_type(flt_type), .flt_access(flt_access), .flt_level(flt_level),
        .flt_bus(flt_bus), .flt_addr(flt_addr), .flt_addr_ok(flt_addr_ok),
        .rd_clr(rd_fsr), .nofault(nofault),
        .fsr(fsr), .far(far_word), .trap(trap_req)
    );

    assign fsr_word    = {{(DATA_W-FSR_W){1'b0}}, fsr};
    assign ctl_word    = {IMPL_ID, VERS_ID, 16'h0, ctl.pso, 5'b0, ctl.nf, ctl.en};
    assign mmu_en      = ctl.en;
    assign store_order = ctl.pso;

    always_comb begin
        cpu_rdata = '0;
        if (rd) begin
            unique case (1'b1)
                hit[RS_CTL]: cpu_rdata = ctl_word;
                hit[RS_CTP]: cpu_rdata = ctx_table_ptr;
                hit[RS_CTX]: cpu_rdata = {{(DATA_W-CTX_W){1'b0}}, ctx_id};
                hit[RS_FSR]: cpu_rdata = fsr_word;
                hit[RS_FAR]: cpu_rdata = far_word;
                default:     cpu_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/mmu_fault_regs_chk.sv
module mmu_fault_regs_chk #(
    parameter logic [3:0] IMPL_ID = 4'hA,
    parameter logic [3:0] VERS_ID = 4'h3,
    parameter int         ADDR_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_sel,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [31:0]       cpu_rdata,
    input logic              flt_valid,
    input logic [2:0]        flt_type,
    input logic              flt_addr_ok,
    input logic              trap_req,
    input logic              nofault,
    input logic [31:0]       fsr_word,
    input logic [31:0]       far_word,
    input logic [31:0]       ctx_table_ptr
);
    p_unmapped_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_sel && !cpu_we && cpu_addr > ADDR_W'(4) |-> cpu_rdata == 32'h0);

    p_ro_ids_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_sel && !cpu_we && cpu_addr == '0 |-> cpu_rdata[31:24] == {IMPL_ID, VERS_ID});

    p_ctp_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_table_ptr[1:0] == 2'b00);

    p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |=> fsr_word[4:2] == $past(flt_type) && fsr_word[31:18] == '0);

    p_far_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid && !flt_addr_ok |=> $stable(far_word) && !fsr_word[1]);

    p_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_sel && !cpu_we && cpu_addr == ADDR_W'(3) && !flt_valid |=> fsr_word[1:0] == 2'b00);

    p_trap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid && !nofault |=> trap_req);

    p_no_trap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_valid || nofault |=> !trap_req);
endmodule

bind mmu_fault_regs mmu_fault_regs_chk #(
    .IMPL_ID(IMPL_ID), .VERS_ID(VERS_ID), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata), .flt_valid(flt_valid),
    .flt_type(flt_type), .flt_addr_ok(flt_addr_ok), .trap_req(trap_req),
    .nofault(nofault), .fsr_word(fsr_word), .far_word(far_word),
    .ctx_table_ptr(ctx_table_ptr)
);

// File: tb/sim_mmu_fault_regs.sv
`timescale 1ns/1ps
module sim_mmu_fault_regs;
    logic        clk = 0, rst_n = 0;
    logic        cpu_sel = 0, cpu_we = 0;
    logic [2:0]  cpu_addr = 0;
    logic [31:0] cpu_wdata = 0, cpu_rdata;
    logic        flt_valid = 0, flt_addr_ok = 0;
    logic [2:0]  flt_type = 0, flt_access = 0;
    logic [1:0]  flt_level = 0;
    logic [7:0]  flt_bus = 0;
    logic [31:0] flt_addr = 0, ctx_table_ptr;
    logic [7:0]  ctx_id;
    logic        trap_req, mmu_en, store_order;
    int          checks = 0, errors = 0;

    always #4 clk = ~clk;

    mmu_fault_regs u0 (.*);

    typedef struct packed {
        logic        we;
        logic [2:0]  a;
        logic [31:0] wd;
        logic [31:0] ex;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VT [14] = '{
        '{1'b1, 3'd0, 32'hFFFF_FFFF, 32'h0,         4'd2},  // R2 write all ones
        '{1'b0, 3'd0, 32'h0,         32'hA300_0083, 4'd2},  // R2 ids fixed
        '{1'b1, 3'd1, 32'h1234_5677, 32'h0,         4'd3},  // R3
        '{1'b0, 3'd1, 32'h0,         32'h1234_5674, 4'd3},  // R3 low bits zero
        '{1'b1, 3'd2, 32'hFFFF_FFFF, 32'h0,         4'd3},  // R3
        '{1'b0, 3'd2, 32'h0,         32'h0000_00FF, 4'd3},  // R3 width
        '{1'b1, 3'd3, 32'hFFFF_FFFF, 32'h0,         4'd9},  // R9
        '{1'b0, 3'd3, 32'h0,         32'h0,         4'd9},  // R9
        '{1'b1, 3'd4, 32'hDEAD_BEEF, 32'h0,         4'd9},  // R9
        '{1'b0, 3'd4, 32'h0,         32'h0,         4'd9},  // R9
        '{1'b0, 3'd5, 32'h0,         32'h0,         4'd1},  // R1 unmapped
        '{1'b0, 3'd7, 32'h0,         32'h0,         4'd1},  // R1 unmapped
        '{1'b1, 3'd0, 32'h0000_0001, 32'h0,         4'd2},  // R2
        '{1'b0, 3'd0, 32'h0,         32'hA300_0001, 4'd2}   // R2
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); cpu_sel = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk); cpu_sel = 0; cpu_we = 0;
    endtask

    task automatic do_read(input string tag, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk); cpu_sel = 1; cpu_we = 0; cpu_addr = a;
        #1 chk(tag, cpu_rdata, exp);
        @(negedge clk); cpu_sel = 0;
    endtask

    task automatic drive_fault(input logic [2:0] t, input logic [2:0] ac, input logic [1:0] l,
                               input logic [7:0] b, input logic [31:0] ad, input logic ok);
        flt_valid = 1; flt_type = t; flt_access = ac; flt_level = l;
        flt_bus = b; flt_addr = ad; flt_addr_ok = ok;
    endtask

    task automatic do_fault(input logic [2:0] t, input logic [2:0] ac, input logic [1:0] l,
                            input logic [7:0] b, input logic [31:0] ad, input logic ok,
                            input logic exp_trap);
        @(negedge clk); drive_fault(t, ac, l, b, ad, ok);
        @(posedge clk); #1 chk("R8 trap", {31'b0, trap_req}, {31'b0, exp_trap});
        @(negedge clk); flt_valid = 0;
        @(posedge clk); #1 chk("R8 trap one cycle", {31'b0, trap_req}, 32'h0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10 reset state
        #1 chk("R10 trap", {31'b0, trap_req}, 32'h0);
        chk("R10 mmu_en", {31'b0, mmu_en}, 32'h0);
        chk("R10 ctp", ctx_table_ptr, 32'h0);
        do_read("R10 ctl", 3'd0, 32'hA300_0000);
        do_read("R10 fsr", 3'd3, 32'h0);

        foreach (VT[i]) begin
            if (VT[i].we) do_write(VT[i].a, VT[i].wd);
            else do_read($sformatf("R%0d vec %0d", VT[i].req, i), VT[i].a, VT[i].ex);
        end
        chk("R3 ctp port", ctx_table_ptr, 32'h1234_5674);
        chk("R3 ctx port", {24'b0, ctx_id}, 32'h0000_00FF);
        chk("R2 enable port", {31'b0, mmu_en}, 32'h1);
        chk("R2 order port", {31'b0, store_order}, 32'h0);

        // R4 capture with valid address
        do_fault(3'd2, 3'd4, 2'd3, 8'h81, 32'h1000_2000, 1'b1, 1'b1);
        do_read("R4 fsr layout", 3'd3, 32'h0002_078A);
        do_read("R7 fav cleared", 3'd3, 32'h0002_0788);
        do_read("R4 far", 3'd4, 32'h1000_2000);
        // R5 address not valid keeps far
        do_fault(3'd1, 3'd0, 2'd1, 8'h00, 32'hFFFF_0000, 1'b0, 1'b1);
        do_read("R5 far held", 3'd4, 32'h1000_2000);
        // R6 second unread fault sets overwrite
        do_fault(3'd5, 3'd1, 2'd0, 8'h02, 32'h2000_0040, 1'b1, 1'b1);
        do_read("R6 overwrite", 3'd3, 32'h0000_0837);
        do_read("R7 ow cleared", 3'd3, 32'h0000_0834);
        do_read("R5 far loaded", 3'd4, 32'h2000_0040);
        do_fault(3'd3, 3'd2, 2'd2, 8'h00, 32'h3000_0000, 1'b1, 1'b1);
        do_read("R7 no ow after read", 3'd3, 32'h0000_024E);
        // R7 read and fault in the same cycle
        do_fault(3'd6, 3'd7, 2'd0, 8'h00, 32'h0000_0040, 1'b1, 1'b1);
        @(negedge clk);
        cpu_sel = 1; cpu_we = 0; cpu_addr = 3'd3;
        drive_fault(3'd4, 3'd3, 2'd1, 8'h00, 32'h0BAD_0000, 1'b0);
        #1 chk("R7 same-cycle old value", cpu_rdata, 32'h0000_00FA);
        @(posedge clk); #1 chk("R8 trap same-cycle", {31'b0, trap_req}, 32'h1);
        @(negedge clk); cpu_sel = 0; flt_valid = 0;
        do_read("R7 same-cycle new no ow", 3'd3, 32'h0000_0170);
        // R8 trap suppress still records
        do_write(3'd0, 32'h0000_0003);
        do_fault(3'd1, 3'd0, 2'd0, 8'h00, 32'h0000_0055, 1'b1, 1'b0);
        do_read("R8 suppressed fsr", 3'd3, 32'h0000_0006);
        do_read("R8 suppressed far", 3'd4, 32'h0000_0055);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule